// File: doc/BRIEF.md
# Palette DAC Hidden Register Sequencer

This block is the host-side register front end of a video palette DAC. The host sees four byte-wide ports: the pixel mask, the palette read index, the palette write index and the palette data. Behind the pixel-mask port sit a hidden command byte and a bank of extended registers. They are reached only through a sequence of mask-port accesses, tracked by a 3-bit unlock counter. Consecutive mask reads move the counter forward. Once it is at 4 or above, mask-port accesses go to the command byte, the two bytes of a 16-bit extended index, or an extended data window that steps the index after each access.

The block also turns the command byte and extended register 3 into a pixel depth code. It raises a one-cycle pulse each time that depth is re-evaluated. The palette RAM, the clock synthesizer and the video pipeline are handled elsewhere. Read data is combinational during a read strobe. State changes at the rising clock edge that ends the access.

Top module: `xdac_regif`

## Requirements
- R1: After reset the unlock counter, the command byte, the pixel mask, the extended index and all extended registers are zero, `depthCode` is 0 (8 bpp) and `depthChg` is low.
- R2: With command bit 4 clear, each mask-port read steps the counter 0→1→2→3→4→0, and 5, 6 or 7 go to 0.
- R3: With command bit 4 set, each mask-port read steps the counter by one from 0 up to 7, and 7 stays at 7.
- R4: A mask-port write goes to the pixel mask at counts 0–3, the command byte at 4, the index low byte at 5, the index high byte at 6 and extended data at 7. The counter then becomes 0 from counts 0–4, 6 from 5, and 7 from 6 or 7.
- R5: A mask-port read returns the pixel mask at counts 0–3, the command byte at 4, the index low byte at 5, the index high byte at 6 and extended data at 7.
- R6: Any read or write of port select 1, 2 or 3 (read index, write index, data) clears the counter to 0. Port select 0 is the pixel mask.
- R7: An extended data write at an index below 256 stores the byte at that index. Every extended data read or write increments the 16-bit index by one.
- R8: Extended data reads return 0x44 at index 0, 0x03 at index 1, 0x88 at index 7 and 0xFF at index 256 or above. Other indices return the stored byte.
- R9: When the depth is evaluated with command bit 3 set, extended register 3 selects the depth: 0, 5, 7 give code 0 (8 bpp); 1, 2, 8 give code 1 (15 bpp); 3, 6 give code 2 (16 bpp); 4, 9 give code 3 (24 bpp); any other value gives code 0.
- R10: When the depth is evaluated with command bit 3 clear, command bits 7:5 select the depth: 5 gives code 1, 6 gives code 2, 7 gives code 3, and any other value gives code 0.
- R11: The depth is evaluated, and `depthChg` is high for the one cycle after the edge, only on a command write that changes bit 3 or any of bits 7:5, or on a write of extended register 3 while command bit 3 is set. `depthCode` never changes without that pulse.
- R12: A cycle with both read and write strobes high changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portSel | input | 2 | 0 pixel mask, 1 read index, 2 write index, 3 palette data |
| rdStb | input | 1 | Read strobe, one access per clock |
| wrStb | input | 1 | Write strobe, one access per clock |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of a valid mask-port read; zero otherwise |
| depthCode | output | 2 | 0: 8 bpp, 1: 15 bpp, 2: 16 bpp, 3: 24 bpp |
| depthChg | output | 1 | One-cycle pulse after a depth evaluation |

## Verification
The assertions assume that a strobe held high for one clock is exactly one access. They also assume that `portSel` and `wrData` are stable around the clock edge, and that reset is held for at least one edge before any access. The stimulus drives every access at the falling edge and removes the strobes right after the rising edge. Each access therefore spans one edge, and only one deliberate cycle holds both strobes high at once. Extended accesses are always preceded by an access to the write-index port, which restarts the unlock sequence from a known count.

// File: rtl/xdac_pkg.sv
package xdac_pkg;

  typedef enum logic [1:0] {
    PORT_MASK = 2'd0,
    PORT_RIDX = 2'd1,
    PORT_WIDX = 2'd2,
    PORT_DATA = 2'd3
  } port_e;

  typedef enum logic [1:0] {
    DEPTH_8  = 2'd0,
    DEPTH_15 = 2'd1,
    DEPTH_16 = 2'd2,
    DEPTH_24 = 2'd3
  } depth_e;

  typedef enum logic [2:0] {
    RSEL_MASK  = 3'd0,
    RSEL_CMD   = 3'd1,
    RSEL_IDXLO = 3'd2,
    RSEL_IDXHI = 3'd3,
    RSEL_EXT   = 3'd4,
    RSEL_NONE  = 3'd5
  } rsel_e;

  typedef struct packed {
    logic  wrMask;
    logic  wrCmd;
    logic  wrIdxLo;
    logic  wrIdxHi;
    logic  wrExt;
    logic  stepIdx;
    logic  evalDepth;
    rsel_e rdSel;
  } dpCtl_t;

  localparam logic [7:0] ID_AT0   = 8'h44;
  localparam logic [7:0] ID_AT1   = 8'h03;
  localparam logic [7:0] ID_AT7   = 8'h88;
  localparam logic [7:0] OUT_FILL = 8'hFF;
  localparam logic [7:0] EVAL_BITS = 8'hE8;

  function automatic logic [2:0] readStep(input logic [2:0] c, input logic longRun);
    if (longRun) return (c == 3'd7) ? 3'd7 : c + 3'd1;
    return (c < 3'd4) ? c + 3'd1 : 3'd0;
  endfunction

  function automatic logic [2:0] writeStep(input logic [2:0] c);
    case (c)
      3'd5:       return 3'd6;
      3'd6, 3'd7: return 3'd7;
      default:    return 3'd0;
    endcase
  endfunction

  function automatic depth_e decodeDepth(input logic [7:0] cmd, input logic [7:0] r3);
    if (cmd[3]) begin
      case (r3)
        8'd1, 8'd2, 8'd8: return DEPTH_15;
        8'd3, 8'd6:       return DEPTH_16;
        8'd4, 8'd9:       return DEPTH_24;
        default:          return DEPTH_8;
      endcase
    end
    case (cmd[7:5])
      3'd5:    return DEPTH_15;
      3'd6:    return DEPTH_16;
      3'd7:    return DEPTH_24;
      default: return DEPTH_8;
    endcase
  endfunction

endpackage

// File: rtl/xdac_ctrl.sv
module xdac_ctrl
  import xdac_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       portSel,
  input  logic             rdStb,
  input  logic             wrStb,
  input  logic [7:0]       wrData,
  input  logic [7:0]       cmdCur,
  input  logic [IDX_W-1:0] idxCur,
  output dpCtl_t           ctl,
  output logic [2:0]       cnt
);

  logic rdOp, wrOp, onMask;

  assign rdOp   = rdStb & ~wrStb;
  assign wrOp   = wrStb & ~rdStb;
  assign onMask = (port_e'(portSel) == PORT_MASK);

  always_comb begin
    ctl       = '0;
    ctl.rdSel = RSEL_NONE;
    if (wrOp && onMask) begin
      case (cnt)
        3'd4:    ctl.wrCmd   = 1'b1;
        3'd5:    ctl.wrIdxLo = 1'b1;
        3'd6:    ctl.wrIdxHi = 1'b1;
        3'd7: begin
          ctl.wrExt   = 1'b1;
          ctl.stepIdx = 1'b1;
        end
        default: ctl.wrMask  = 1'b1;
      endcase
    end
    if (rdOp && onMask) begin
      case (cnt)
        3'd4:    ctl.rdSel = RSEL_CMD;
        3'd5:    ctl.rdSel = RSEL_IDXLO;
        3'd6:    ctl.rdSel = RSEL_IDXHI;
        3'd7: begin
          ctl.rdSel   = RSEL_EXT;
          ctl.stepIdx = 1'b1;
        end
        default: ctl.rdSel = RSEL_MASK;
      endcase
    end
    ctl.evalDepth = (ctl.wrCmd && (|((cmdCur ^ wrData) & EVAL_BITS)))
                 || (ctl.wrExt && cmdCur[3] && (idxCur == IDX_W'(3)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= 3'd0;
    end else if (rdOp || wrOp) begin
      if (!onMask)   cnt <= 3'd0;
      else if (rdOp) cnt <= readStep(cnt, cmdCur[4]);
      else           cnt <= writeStep(cnt);
    end
  end

endmodule

// File: rtl/xdac_dp.sv
module xdac_dp
  import xdac_pkg::*;
#(
  parameter int IDX_W    = 16,
  parameter int EXT_REGS = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  output logic [7:0]       cmdReg,
  output logic [IDX_W-1:0] idxReg,
  output logic [1:0]       depthCode,
  output logic             depthChg
);

  localparam int AW = $clog2(EXT_REGS);

  logic [7:0] maskReg;
  logic [7:0] extRegs [EXT_REGS];
  logic       idxInRange;
  logic [7:0] extRead;
  logic [7:0] cmdNext, r3Next;

  assign idxInRange = (idxReg < IDX_W'(EXT_REGS));

  always_comb begin
    if (idxReg == IDX_W'(0))      extRead = ID_AT0;
    else if (idxReg == IDX_W'(1)) extRead = ID_AT1;
    else if (idxReg == IDX_W'(7)) extRead = ID_AT7;
    else if (idxInRange)          extRead = extRegs[idxReg[AW-1:0]];
    else                          extRead = OUT_FILL;
  end

  always_comb begin
    case (ctl.rdSel)
      RSEL_MASK:  rdData = maskReg;
      RSEL_CMD:   rdData = cmdReg;
      RSEL_IDXLO: rdData = idxReg[7:0];
      RSEL_IDXHI: rdData = idxReg[15:8];
      RSEL_EXT:   rdData = extRead;
      default:    rdData = 8'h00;
    endcase
  end

  assign cmdNext = ctl.wrCmd ? wrData : cmdReg;
  assign r3Next  = (ctl.wrExt && idxReg == IDX_W'(3)) ? wrData : extRegs[3];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg   <= 8'h00;
      cmdReg    <= 8'h00;
      idxReg    <= '0;
      depthCode <= DEPTH_8;
      depthChg  <= 1'b0;
      for (int i = 0; i < EXT_REGS; i++) extRegs[i] <= 8'h00;
    end else begin
      depthChg <= ctl.evalDepth;
      if (ctl.evalDepth) depthCode <= decodeDepth(cmdNext, r3Next);
      if (ctl.wrMask)    maskReg <= wrData;
      if (ctl.wrCmd)     cmdReg  <= wrData;
      if (ctl.wrExt && idxInRange) extRegs[idxReg[AW-1:0]] <= wrData;
      if (ctl.wrIdxLo)      idxReg[7:0]  <= wrData;
      else if (ctl.wrIdxHi) idxReg[15:8] <= wrData;
      else if (ctl.stepIdx) idxReg       <= idxReg + IDX_W'(1);
    end
  end

endmodule

// File: rtl/xdac_regif.sv
module xdac_regif
  import xdac_pkg::*;
#(
  parameter int IDX_W    = 16,
  parameter int EXT_REGS = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] portSel,
  input  logic       rdStb,
  input  logic       wrStb,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic [1:0] depthCode,
  output logic       depthChg
);

  dpCtl_t           ctl;
  logic [2:0]       unlockCnt;
  logic [7:0]       cmdVal;
  logic [IDX_W-1:0] idxVal;

  xdac_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .portSel(portSel), .rdStb(rdStb), .wrStb(wrStb),
    .wrData(wrData), .cmdCur(cmdVal), .idxCur(idxVal), .ctl(ctl), .cnt(unlockCnt)
  );

  xdac_dp #(.IDX_W(IDX_W), .EXT_REGS(EXT_REGS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData), .rdData(rdData),
    .cmdReg(cmdVal), .idxReg(idxVal), .depthCode(depthCode), .depthChg(depthChg)
  );

endmodule

// File: rtl/xdac_chk.sv
module xdac_chk #(
  parameter int IDX_W    = 16,
  parameter int EXT_REGS = 256
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       portSel,
  input logic             rdStb,
  input logic             wrStb,
  input logic [7:0]       rdData,
  input logic [1:0]       depthCode,
  input logic             depthChg,
  input logic [2:0]       unlockCnt,
  input logic [7:0]       cmdVal,
  input logic [IDX_W-1:0] idxVal
);

  logic maskRd, maskWr;
  assign maskRd = rdStb && !wrStb && portSel == 2'd0;
  assign maskWr = wrStb && !rdStb && portSel == 2'd0;

  AST_PALETTE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ((rdStb ^ wrStb) && portSel != 2'd0) |=> unlockCnt == 3'd0); // R6

  AST_SHORT_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (maskRd && !cmdVal[4]) |=> unlockCnt <= 3'd4); // R2

  AST_LOW_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (maskWr && unlockCnt < 3'd5) |=> unlockCnt == 3'd0); // R4

  AST_ID_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (maskRd && unlockCnt == 3'd7 && idxVal == '0) |-> rdData == 8'h44); // R8

  AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (maskRd && unlockCnt == 3'd7 && idxVal >= IDX_W'(EXT_REGS)) |-> rdData == 8'hFF); // R8

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (maskRd && unlockCnt == 3'd7) |=> idxVal == $past(idxVal) + IDX_W'(1)); // R7

  AST_DEPTH_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (depthCode != $past(depthCode)) |-> depthChg); // R11

  AST_DUAL_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && wrStb) |=> ($stable(unlockCnt) && $stable(cmdVal) && $stable(idxVal))); // R12

endmodule

bind xdac_regif xdac_chk #(.IDX_W(IDX_W), .EXT_REGS(EXT_REGS)) u_chk (
  .clk(clk), .rstN(rstN), .portSel(portSel), .rdStb(rdStb), .wrStb(wrStb),
  .rdData(rdData), .depthCode(depthCode), .depthChg(depthChg),
  .unlockCnt(unlockCnt), .cmdVal(cmdVal), .idxVal(idxVal)
);

// File: tb/sim_xdac_regif.sv
`timescale 1ns/1ps
module sim_xdac_regif;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] portSel = 2'd0;
  logic       rdStb = 1'b0;
  logic       wrStb = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [1:0] depthCode;
  logic       depthChg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xdac_regif u0 (
    .clk(clk), .rstN(rstN), .portSel(portSel), .rdStb(rdStb), .wrStb(wrStb),
    .wrData(wrData), .rdData(rdData), .depthCode(depthCode), .depthChg(depthChg)
  );

  typedef struct packed {
    logic       w;
    logic [1:0] p;
    logic [7:0] d;
    logic [7:0] e;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 8'h5A, 8'h00, 4'd4},  // R4 mask write at count 0
    '{1'b0, 2'd0, 8'h00, 8'h5A, 4'd5},  // R5 count 0 -> 1
    '{1'b0, 2'd0, 8'h00, 8'h5A, 4'd5},
    '{1'b0, 2'd0, 8'h00, 8'h5A, 4'd5},
    '{1'b0, 2'd0, 8'h00, 8'h5A, 4'd5},  // count now 4
    '{1'b0, 2'd0, 8'h00, 8'h00, 4'd5},  // R5 command at 4, R2 4 -> 0
    '{1'b0, 2'd0, 8'h00, 8'h5A, 4'd2},  // R2 wrapped to 0
    '{1'b0, 2'd0, 8'h00, 8'h5A, 4'd2},
    '{1'b0, 2'd0, 8'h00, 8'h5A, 4'd2},
    '{1'b0, 2'd0, 8'h00, 8'h5A, 4'd2},  // count 4
    '{1'b1, 2'd0, 8'h10, 8'h00, 4'd4},  // R4 command write, 4 -> 0
    '{1'b0, 2'd0, 8'h00, 8'h5A, 4'd3},
    '{1'b0, 2'd0, 8'h00, 8'h5A, 4'd3},
    '{1'b0, 2'd0, 8'h00, 8'h5A, 4'd3},
    '{1'b0, 2'd0, 8'h00, 8'h5A, 4'd3},  // count 4
    '{1'b0, 2'd0, 8'h00, 8'h10, 4'd3},  // R3 command read, 4 -> 5
    '{1'b0, 2'd0, 8'h00, 8'h00, 4'd5},  // index low, 5 -> 6
    '{1'b0, 2'd0, 8'h00, 8'h00, 4'd5},  // index high, 6 -> 7
    '{1'b0, 2'd0, 8'h00, 8'h44, 4'd8},  // R8 index 0
    '{1'b0, 2'd0, 8'h00, 8'h03, 4'd8},  // R8 index 1, R3 stays at 7
    '{1'b0, 2'd0, 8'h00, 8'h00, 4'd7},  // R7 stored index 2
    '{1'b1, 2'd1, 8'h00, 8'h00, 4'd6},  // R6 read-index port clears
    '{1'b0, 2'd0, 8'h00, 8'h5A, 4'd6}   // R6 back to pixel mask
  };

  task automatic check(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic acc(input bit w, input logic [1:0] p, input logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    portSel = p; wrStb = w; rdStb = !w; wrData = d;
    #2 r = rdData;
    @(posedge clk);
    #1 wrStb = 1'b0; rdStb = 1'b0;
  endtask

  task automatic wr(input logic [1:0] p, input logic [7:0] d);
    logic [7:0] unused;
    acc(1'b1, p, d, unused);
  endtask

  task automatic rd(output logic [7:0] r);
    acc(1'b0, 2'd0, 8'h00, r);
  endtask

  task automatic reach(input int k);
    logic [7:0] t;
    wr(2'd2, 8'h00);
    for (int i = 0; i < k; i++) rd(t);
  endtask

  task automatic setIdx(input logic [7:0] lo);
    reach(5);
    wr(2'd0, lo);
    wr(2'd0, 8'h00);
  endtask

  task automatic writeCmd(input logic [7:0] v);
    reach(4);
    wr(2'd0, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    #2;
    check(1, "depth after reset", {6'd0, depthCode}, 8'd0);
    check(1, "pulse after reset", {7'd0, depthChg}, 8'd0);

    for (int v = 0; v < NV; v++) begin
      acc(VECS[v].w, VECS[v].p, VECS[v].d, r);
      if (!VECS[v].w) check(int'(VECS[v].req), $sformatf("vector %0d", v), r, VECS[v].e);
    end

    // R7 store then read back
    setIdx(8'h20);
    wr(2'd0, 8'hA1);
    wr(2'd0, 8'hB2);
    setIdx(8'h20);
    rd(r); check(7, "ext 0x20", r, 8'hA1);
    rd(r); check(7, "ext 0x21", r, 8'hB2);
    reach(5);
    rd(r); check(5, "index low after steps", r, 8'h22);

    // R8 hard-wired id at 7
    setIdx(8'h07);
    rd(r); check(8, "ext 7 id", r, 8'h88);

    // R7 top of file, R8 past it
    setIdx(8'hFF);
    wr(2'd0, 8'h77);
    setIdx(8'hFF);
    rd(r); check(7, "ext 0xFF", r, 8'h77);
    rd(r); check(8, "ext 0x100", r, 8'hFF);
    reach(6);
    rd(r); check(5, "index high", r, 8'h01);

    // R10 depth from command bits 7:5, R11 pulse
    writeCmd(8'hB0);
    check(10, "cmd 101 depth", {6'd0, depthCode}, 8'd1);
    check(11, "cmd pulse", {7'd0, depthChg}, 8'd1);
    wr(2'd2, 8'h00);
    check(11, "pulse drops", {7'd0, depthChg}, 8'd0);
    writeCmd(8'hD0);
    check(10, "cmd 110 depth", {6'd0, depthCode}, 8'd2);
    writeCmd(8'hF0);
    check(10, "cmd 111 depth", {6'd0, depthCode}, 8'd3);
    writeCmd(8'h30);
    check(10, "cmd 001 depth", {6'd0, depthCode}, 8'd0);

    // R11 reg 3 write with command bit 3 clear does not evaluate
    setIdx(8'h03);
    wr(2'd0, 8'h06);
    check(11, "reg3 no pulse", {7'd0, depthChg}, 8'd0);

    // R9 command bit 3 set selects reg 3
    writeCmd(8'h38);
    check(9, "reg3=6 depth", {6'd0, depthCode}, 8'd2);
    check(11, "bit3 toggle pulse", {7'd0, depthChg}, 8'd1);
    setIdx(8'h03);
    wr(2'd0, 8'h09);
    check(9, "reg3=9 depth", {6'd0, depthCode}, 8'd3);
    check(11, "reg3 write pulse", {7'd0, depthChg}, 8'd1);
    setIdx(8'h03);
    wr(2'd0, 8'h02);
    check(9, "reg3=2 depth", {6'd0, depthCode}, 8'd1);
    setIdx(8'h03);
    wr(2'd0, 8'h0A);
    check(9, "reg3=10 depth", {6'd0, depthCode}, 8'd0);

    // R11 command rewrite with same bits
    writeCmd(8'h38);
    check(11, "same cmd no pulse", {7'd0, depthChg}, 8'd0);

    // R12 both strobes at count 4
    reach(4);
    @(negedge clk);
    portSel = 2'd0; rdStb = 1'b1; wrStb = 1'b1; wrData = 8'hEE;
    @(posedge clk);
    #1 rdStb = 1'b0; wrStb = 1'b0;
    rd(r); check(12, "dual strobe no-op", r, 8'h38);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule